// File: doc/BRIEF.md
# Stack-Pointer-Gated Interrupt Arbiter

This block keeps the two stack pointers of a small 4-bit controller core and decides when an interrupt may be taken. The wide pointer is 10 bits and serves 16-bit stack traffic. The narrow pointer is 8 bits and serves 4-bit stack traffic. Each pointer can be loaded by software or stepped up or down by the core, and it wraps around within its own range.

Interrupt acceptance is gated on software having initialised both pointers as a pair. After reset no interrupt is taken, not even the non-maskable one, until both pointers have been written. If both are already written and software then rewrites only one of them, acceptance closes again until the other pointer is rewritten too. When acceptance is open, the block picks the winning request, registers its vector address and raises a one-cycle accept pulse.

All pins are plain control and status signals. There is no valid/ready handshake and no back-pressure. A request is sampled on every clock edge, and the core must act on the accept pulse in the cycle it appears. After reset the vector output carries the program start address.

Top module: `stkptr_irq_arbiter`

## Requirements
- R1: While reset is held and right after it, both pointers read 0, `vec_addr` reads 0x0110, `irq_take` is low, and neither pointer counts as written.
- R2: The wide pointer (10 bits) loads `wa_data` on the edge where `wa_en` is high. Otherwise it steps +1 on `inc_a` or −1 on `dec_a`, wrapping modulo 1024. A write beats a step, and `inc_a` together with `dec_a` leaves the pointer unchanged.
- R3: The narrow pointer (8 bits) follows the same rules as R2 with `wb_en`, `wb_data`, `inc_b` and `dec_b`, wrapping modulo 256.
- R4: After reset, `irq_take` stays low for any request until both pointers have been written.
- R5: When both pointers are written and one is rewritten alone, the other's written state is cleared and no request is accepted until that other pointer is written. Writing both pointers on the same edge keeps acceptance open.
- R6: When acceptance is open and `nmi_req` is high, the NMI wins over every hardware request, and its vector is 0x0100.
- R7: Hardware request bit i (0..6) has vector 0x0102 + 2·i, spanning 0x0102 to 0x010E. The lowest set bit wins.
- R8: `irq_take` is high for exactly one cycle, on the edge after an open gate sees a request. `vec_addr` updates on that edge and holds until the next accept. A request held high is accepted on every second cycle.
- R9: `sp16_oob` is high whenever the wide pointer lies outside 0x0100 to 0x01FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wa_en | input | 1 | Software write of the wide pointer |
| wa_data | input | 10 | Value written to the wide pointer |
| inc_a | input | 1 | Step the wide pointer up |
| dec_a | input | 1 | Step the wide pointer down |
| wb_en | input | 1 | Software write of the narrow pointer |
| wb_data | input | 8 | Value written to the narrow pointer |
| inc_b | input | 1 | Step the narrow pointer up |
| dec_b | input | 1 | Step the narrow pointer down |
| nmi_req | input | 1 | Non-maskable interrupt request |
| hw_req | input | 7 | Hardware interrupt requests, bit 0 highest priority |
| sp_a | output | 10 | Wide (16-bit data) stack pointer |
| sp_b | output | 8 | Narrow (4-bit data) stack pointer |
| sp16_oob | output | 1 | Wide pointer outside the 16-bit-capable window |
| vec_addr | output | 16 | Last accepted vector, or the start address after reset |
| irq_take | output | 1 | One-cycle accept pulse |

## Verification
The arbiter is driven with single hardware bits at both ends of the request vector, with a dense vector where every bit is set, and with the NMI together with a hardware bit. These patterns show whether the design picks the lowest bit and puts NMI first. Requests held before the pair is complete, after a lone rewrite, and after a joint rewrite separate the three gate states. A request held for four cycles shows the alternating pulse. The pointers are stepped across their top and bottom boundaries, with write/step and up/down collisions, and the out-of-window flag is read on both sides of its window.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int ADDR_W   = 16;
  localparam int SPA_W    = 10;
  localparam int SPB_W    = 8;
  localparam int N_HW     = 7;
  localparam logic [ADDR_W-1:0] START_VEC = 16'h0110;
  localparam logic [ADDR_W-1:0] NMI_VEC   = 16'h0100;
  localparam logic [ADDR_W-1:0] HW_BASE   = 16'h0102;
  localparam logic [ADDR_W-1:0] WIN_LO    = 16'h0100;
  localparam logic [ADDR_W-1:0] WIN_HI    = 16'h01FF;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)            q <= '0;
    else if (wr)           q <= din;
    else if (inc && !dec)  q <= q + ONE;
    else if (dec && !inc)  q <= q - ONE;
  end

  // R2
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && !wr && q == TOP) |=> q == '0);
  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q == $past(din));
endmodule

// File: rtl/pair_gate.sv
module pair_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_a,
  input  logic wr_b,
  output logic open
);
  logic done_a, done_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_a <= 1'b0;
      done_b <= 1'b0;
    end else begin
      if (wr_a) done_a <= 1'b1;
      if (wr_b) done_b <= 1'b1;
      if (done_a && done_b) begin
        if (wr_a && !wr_b) done_b <= 1'b0;
        if (wr_b && !wr_a) done_a <= 1'b0;
      end
    end
  end

  assign open = done_a && done_b;

  // R5
  lone_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_a && done_b && wr_a && !wr_b) |=> (done_a && !done_b));
  // R4
  reset_closed_chk: assert property (@(posedge clk)
    !rst_n |=> !open);
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import stk_pkg::*;
#(
  parameter int N = N_HW
) (
  input  logic              nmi,
  input  logic [N-1:0]      hw,
  output logic              any,
  output logic [ADDR_W-1:0] vec
);
  always_comb begin
    vec = NMI_VEC;
    for (int i = N - 1; i >= 0; i--) begin
      if (hw[i]) vec = HW_BASE + ADDR_W'(2 * i);
    end
    if (nmi) vec = NMI_VEC;
  end

  assign any = nmi || (|hw);
endmodule

// File: rtl/stkptr_irq_arbiter.sv
module stkptr_irq_arbiter
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_en,
  input  logic [SPA_W-1:0]  wa_data,
  input  logic              inc_a,
  input  logic              dec_a,
  input  logic              wb_en,
  input  logic [SPB_W-1:0]  wb_data,
  input  logic              inc_b,
  input  logic              dec_b,
  input  logic              nmi_req,
  input  logic [N_HW-1:0]   hw_req,
  output logic [SPA_W-1:0]  sp_a,
  output logic [SPB_W-1:0]  sp_b,
  output logic              sp16_oob,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              irq_take
);
  logic              gate_open;
  logic              req_any;
  logic [ADDR_W-1:0] req_vec;
  logic [ADDR_W-1:0] sp_a_ext;

  stk_ptr #(.W(SPA_W)) u_spa (
    .clk(clk), .rst_n(rst_n), .wr(wa_en), .din(wa_data),
    .inc(inc_a), .dec(dec_a), .q(sp_a)
  );

  stk_ptr #(.W(SPB_W)) u_spb (
    .clk(clk), .rst_n(rst_n), .wr(wb_en), .din(wb_data),
    .inc(inc_b), .dec(dec_b), .q(sp_b)
  );

  pair_gate u_gate (
    .clk(clk), .rst_n(rst_n), .wr_a(wa_en), .wr_b(wb_en), .open(gate_open)
  );

  irq_pick #(.N(N_HW)) u_pick (
    .nmi(nmi_req), .hw(hw_req), .any(req_any), .vec(req_vec)
  );

  assign sp_a_ext = ADDR_W'(sp_a);
  assign sp16_oob = (sp_a_ext < WIN_LO) || (sp_a_ext > WIN_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_take <= 1'b0;
      vec_addr <= START_VEC;
    end else if (gate_open && req_any && !irq_take) begin
      irq_take <= 1'b1;
      vec_addr <= req_vec;
    end else begin
      irq_take <= 1'b0;
    end
  end

  // R8
  take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_take);
  // R4
  take_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(gate_open));
  // R6
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && nmi_req && !irq_take) |=> (irq_take && vec_addr == NMI_VEC));
  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_take |-> $stable(vec_addr) || $past(!rst_n));
endmodule

// File: tb/stkptr_irq_arbiter_tb.sv
module stkptr_irq_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wa_en = 0, inc_a = 0, dec_a = 0, wb_en = 0, inc_b = 0, dec_b = 0, nmi_req = 0;
  logic [9:0]  wa_data = '0;
  logic [7:0]  wb_data = '0;
  logic [6:0]  hw_req = '0;
  logic [9:0]  sp_a;
  logic [7:0]  sp_b;
  logic        sp16_oob, irq_take;
  logic [15:0] vec_addr;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  stkptr_irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .wa_en(wa_en), .wa_data(wa_data), .inc_a(inc_a),
    .dec_a(dec_a), .wb_en(wb_en), .wb_data(wb_data), .inc_b(inc_b), .dec_b(dec_b),
    .nmi_req(nmi_req), .hw_req(hw_req), .sp_a(sp_a), .sp_b(sp_b),
    .sp16_oob(sp16_oob), .vec_addr(vec_addr), .irq_take(irq_take)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_take(input string tag, input logic [15:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every accept must match the head of the expected queue
  always @(negedge clk) begin
    if (rst_n && irq_take) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4 unexpected accept actual=%h expected=none", vec_addr);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (vec_addr !== e) begin
          n_fail++;
          $display("FAIL %s accept vector actual=%h expected=%h", t, vec_addr, e);
        end
      end
    end
  end

  initial begin
    cyc(200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 sp_a", 16'(sp_a), 16'h0);
    chk("R1 vec", vec_addr, 16'h0110);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 sp_b", 16'(sp_b), 16'h0);
    chk("R1 take", 16'(irq_take), 16'h0);
    chk("R9 oob at 0", 16'(sp16_oob), 16'h1);
    // R4: nothing taken before pairing
    nmi_req = 1; cyc(3);
    chk("R4 closed no writes", 16'(irq_take), 16'h0);
    wa_en = 1; wa_data = 10'h100; cyc(1); wa_en = 0; cyc(2);
    chk("R2 load", 16'(sp_a), 16'h0100);
    chk("R9 oob in window", 16'(sp16_oob), 16'h0);
    chk("R4 closed one write", 16'(irq_take), 16'h0);
    expect_take("R6 first nmi", 16'h0100);
    wb_en = 1; wb_data = 8'h80; cyc(1);
    chk("R8 no take on pairing edge", 16'(irq_take), 16'h0);
    wb_en = 0; cyc(1);
    chk("R8 take", 16'(irq_take), 16'h1);
    nmi_req = 0; cyc(1);
    chk("R8 pulse ends", 16'(irq_take), 16'h0);
    chk("R3 load", 16'(sp_b), 16'h0080);
    cyc(1);
    // R7 hardware priority
    hw_req = 7'b0010100; expect_take("R7 bits2,4", 16'h0106); cyc(1); hw_req = 0; cyc(2);
    hw_req = 7'b1000000; expect_take("R7 bit6", 16'h010E); cyc(1); hw_req = 0; cyc(2);
    hw_req = 7'b1111111; expect_take("R7 all", 16'h0102); cyc(1); hw_req = 0; cyc(2);
    nmi_req = 1; hw_req = 7'b0001000; expect_take("R6 nmi over hw", 16'h0100);
    cyc(1); nmi_req = 0; hw_req = 0; cyc(2);
    chk("R8 vec holds", vec_addr, 16'h0100);
    // R8 held request alternates
    hw_req = 7'b0100000; expect_take("R8 held 1", 16'h010C); expect_take("R8 held 2", 16'h010C);
    cyc(1); chk("R8 held c1", 16'(irq_take), 16'h1);
    cyc(1); chk("R8 held c2", 16'(irq_take), 16'h0);
    cyc(1); chk("R8 held c3", 16'(irq_take), 16'h1);
    cyc(1); chk("R8 held c4", 16'(irq_take), 16'h0);
    hw_req = 0; cyc(2);
    // R5 lone rewrite closes the gate
    wa_en = 1; wa_data = 10'h1FF; cyc(1); wa_en = 0; nmi_req = 1; cyc(3);
    chk("R5 closed after lone rewrite", 16'(irq_take), 16'h0);
    chk("R9 top of window", 16'(sp16_oob), 16'h0);
    expect_take("R5 reopened", 16'h0100);
    wb_en = 1; wb_data = 8'h10; cyc(1); wb_en = 0; cyc(1); nmi_req = 0; cyc(2);
    // R5 joint write keeps open
    wa_en = 1; wa_data = 10'h3FF; wb_en = 1; wb_data = 8'hFF; cyc(1);
    wa_en = 0; wb_en = 0; nmi_req = 1; expect_take("R5 joint write", 16'h0100);
    cyc(1); nmi_req = 0; cyc(2);
    chk("R9 above window", 16'(sp16_oob), 16'h1);
    // R2/R3 wrap
    inc_a = 1; inc_b = 1; cyc(1); inc_a = 0; inc_b = 0;
    chk("R2 wrap up", 16'(sp_a), 16'h0);
    chk("R3 wrap up", 16'(sp_b), 16'h0);
    dec_a = 1; dec_b = 1; cyc(1); dec_a = 0; dec_b = 0;
    chk("R2 wrap down", 16'(sp_a), 16'h03FF);
    chk("R3 wrap down", 16'(sp_b), 16'h00FF);
    inc_a = 1; dec_a = 1; inc_b = 1; dec_b = 1; cyc(1);
    inc_a = 0; dec_a = 0; inc_b = 0; dec_b = 0;
    chk("R2 inc+dec hold", 16'(sp_a), 16'h03FF);
    chk("R3 inc+dec hold", 16'(sp_b), 16'h00FF);
    wa_en = 1; wa_data = 10'h150; inc_a = 1; wb_en = 1; wb_data = 8'h22; dec_b = 1; cyc(1);
    wa_en = 0; inc_a = 0; wb_en = 0; dec_b = 0;
    chk("R2 write beats step", 16'(sp_a), 16'h0150);
    chk("R3 write beats step", 16'(sp_b), 16'h0022);
    wa_en = 1; wa_data = 10'h200; cyc(1); wa_en = 0;
    chk("R9 at 0x200", 16'(sp16_oob), 16'h1);
    wa_en = 1; wa_data = 10'h0FF; cyc(1); wa_en = 0;
    chk("R9 at 0x0FF", 16'(sp16_oob), 16'h1);
    cyc(3);
    chk("R8 all expected accepts seen", 16'(exp_q.size()), 16'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule